// File: doc/BRIEF.md
# SDRAM Bank and Power-State Tracker

This block sits beside a four-bank double-data-rate SDRAM and watches its command bus. It decodes each command sampled at the rising clock edge and keeps a per-bank record of whether a row is open and which row that is. It also follows the device through normal operation, the two power-down modes and self refresh. It flags commands that make no sense for the current bank state. A controller or monitor uses the outputs to see the memory's state without tracking it again on its own.

Address bit 10 means different things for different commands. On a read or write it asks for the bank to close by itself once the access is over. On a precharge it closes every bank, and the bank-select bits are then ignored. The power-down mode entered when clock enable falls depends on whether any bank holds a row. A configuration input picks the column width of the x8 or x16 organisation.

Top module: `sdram_bank_tracker`

## Requirements
- R1: With cs_n high the decoded command is NOP (code 0). With cs_n low, {ras_n,cas_n,we_n} decodes as 011 Active (1), 101 Read (2), 100 Write (3), 010 Precharge (4), 001 Refresh (5) and 000 Mode Register Set (6). Every other pattern is NOP. `cmd` shows the command one cycle after its sampling edge.
- R2: An Active to an idle bank opens it and stores addr as its row. The bank's slice of `open_row` (bank b at bits b*ROW_W upward) shows that row while the bank is open and reads zero while it is idle.
- R3: A Precharge with addr[10] low closes only the bank on `ba`. With addr[10] high it closes all banks whatever `ba` holds.
- R4: A legal Read or Write with addr[10] high keeps its bank open for BURST_CYC more edges, then closes it. A Precharge closes the bank at once.
- R5: On a Read or Write, `col_addr` holds addr[9:0] when org_x16 is 0, or addr[8:0] with bit 9 zero when org_x16 is 1. For any other command it is zero.
- R6: `illegal` rises for one cycle for these commands: a Read or Write to an idle bank, or to a bank whose automatic close is pending; an Active to an open bank; a Refresh or self-refresh entry while any bank is open. An illegal command changes no bank state.
- R7: When cke is sampled low in normal mode (pwr_mode 0) without a refresh, the mode becomes precharge power-down (1) if all banks are idle. If any bank is open it becomes active power-down (2).
- R8: cke sampled low with a Refresh while all banks are idle enters self refresh (pwr_mode 3), and `cmd` shows code 7. If a bank is open, the command is flagged illegal and active power-down is entered instead.
- R9: While pwr_mode is not 0, a low cke keeps the mode and a high cke returns it to 0. Commands are carried out only when cke is high in mode 0; all others read as NOP. Banks stay idle in self refresh.
- R10: A synchronous reset closes all banks, cancels pending closes and sets pwr_mode to 0, cmd to NOP and illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ROW_W | Address bus |
| ba | input | BA_W | Bank select |
| org_x16 | input | 1 | 1 selects the x16 column width |
| cmd | output | 3 | Decoded command code |
| col_addr | output | COL_X8_W | Column address of the last Read/Write |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| open_row | output | NUM_BANKS*ROW_W | Per-bank open row |
| pwr_mode | output | 2 | 0 normal, 1 precharge PD, 2 active PD, 3 self refresh |
| illegal | output | 1 | Illegal-command flag |

## Verification
The bench builds the tracker with four banks, 13 row bits and BURST_CYC set to 3. The three-edge auto-close window gives time to issue a second access or a precharge to a bank while its close is pending. It also allows a power-down entry to fall inside the window. These cases are tested alongside directed decode, precharge and power-state sequences. A run of random commands follows them.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_X8_W  = 10,
  parameter int COL_X16_W = 9,
  parameter int AP_BIT    = 10,
  parameter int BURST_CYC = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [ROW_W-1:0]           addr,
  input  logic [BA_W-1:0]            ba,
  input  logic                       org_x16,
  output logic [2:0]                 cmd,
  output logic [COL_X8_W-1:0]        col_addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic [1:0]                 pwr_mode,
  output logic                       illegal
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);
  localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_CYC);
  localparam logic [COL_X8_W-1:0] X16_MASK = COL_X8_W'((1 << COL_X16_W) - 1);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_SRE = 3'd7;
  localparam logic [1:0] P_NORM = 2'd0, P_PPD = 2'd1, P_APD = 2'd2, P_SR = 2'd3;

  logic [2:0] raw, dec;
  logic       ill_d;
  logic       open_b [NUM_BANKS];
  logic [CNT_W-1:0] cnt_b [NUM_BANKS];
  logic [ROW_W-1:0] row_b [NUM_BANKS];

  always_comb begin
    case ({ras_n, cas_n, we_n})
      3'b011:  raw = C_ACT;
      3'b101:  raw = C_RD;
      3'b100:  raw = C_WR;
      3'b010:  raw = C_PRE;
      3'b001:  raw = C_REF;
      3'b000:  raw = C_MRS;
      default: raw = C_NOP;
    endcase
  end

  wire awake    = (pwr_mode == P_NORM) && cke;
  wire entering = (pwr_mode == P_NORM) && !cke;
  wire any_open = |bank_open;
  wire sel_open = open_b[ba];
  wire sel_busy = cnt_b[ba] != '0;
  wire ap       = addr[AP_BIT];
  wire is_rw    = (dec == C_RD) || (dec == C_WR);

  always_comb begin
    if (cs_n)                          dec = C_NOP;
    else if (awake)                    dec = raw;
    else if (entering && raw == C_REF) dec = C_SRE;
    else                               dec = C_NOP;
  end

  always_comb begin
    ill_d = 1'b0;
    if (is_rw && (!sel_open || sel_busy))           ill_d = 1'b1;
    if (dec == C_ACT && sel_open)                    ill_d = 1'b1;
    if ((dec == C_REF || dec == C_SRE) && any_open)  ill_d = 1'b1;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    wire hit = ba == BA_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        open_b[g] <= 1'b0;
        cnt_b[g]  <= '0;
        row_b[g]  <= '0;
      end else begin
        if (cnt_b[g] != '0) begin
          cnt_b[g] <= cnt_b[g] - 1'b1;
          if (cnt_b[g] == CNT_W'(1)) open_b[g] <= 1'b0;
        end
        if (dec == C_ACT && hit && !open_b[g]) begin
          open_b[g] <= 1'b1;
          row_b[g]  <= addr;
        end
        if (dec == C_PRE && (ap || hit)) begin
          open_b[g] <= 1'b0;
          cnt_b[g]  <= '0;
        end
        if (is_rw && hit && ap && !ill_d) cnt_b[g] <= BURST_LD;
        if (pwr_mode == P_SR) open_b[g] <= 1'b0;
      end
    end
    assign bank_open[g] = open_b[g];
    assign open_row[g*ROW_W +: ROW_W] = open_b[g] ? row_b[g] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_mode <= P_NORM;
    end else if (pwr_mode == P_NORM) begin
      if (!cke)
        pwr_mode <= (dec == C_SRE && !any_open) ? P_SR : (any_open ? P_APD : P_PPD);
    end else if (cke) begin
      pwr_mode <= P_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= C_NOP;
      illegal  <= 1'b0;
      col_addr <= '0;
    end else begin
      cmd      <= dec;
      illegal  <= ill_d;
      col_addr <= is_rw ? (addr[COL_X8_W-1:0] & (org_x16 ? X16_MASK : '1)) : '0;
    end
  end
endmodule

module sdram_bank_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_X8_W  = 10,
  parameter int COL_X16_W = 9,
  parameter int AP_BIT    = 10,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [ROW_W-1:0]     addr,
  input logic [BA_W-1:0]      ba,
  input logic                 org_x16,
  input logic [2:0]           cmd,
  input logic [COL_X8_W-1:0]  col_addr,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [1:0]           pwr_mode,
  input logic                 illegal
);
  wire live = !cs_n && cke && pwr_mode == 2'd0;
  wire [2:0] rcw = {ras_n, cas_n, we_n};

  assert_deselect_nop_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> cmd == 3'd0);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
    (live && rcw == 3'b011 && !bank_open[ba]) |=> bank_open[$past(ba)]);

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    (live && rcw == 3'b010 && addr[AP_BIT]) |=> bank_open == '0);

  assert_x16_col_R5: assert property (@(posedge clk) disable iff (rst)
    org_x16 |=> col_addr[COL_X8_W-1:COL_X16_W] == '0);

  assert_rd_idle_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (live && rcw == 3'b101 && !bank_open[ba]) |=> illegal);

  assert_active_pd_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd0 && !cke && |bank_open) |=> pwr_mode == 2'd2);

  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode != 2'd0 && !cke) |=> $stable(pwr_mode));

  assert_pd_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode != 2'd0 && cke) |=> pwr_mode == 2'd0);

  assert_sr_idle_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_mode == 2'd3 |-> bank_open == '0);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (bank_open == '0 && pwr_mode == 2'd0 && !illegal));
endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_X8_W(COL_X8_W),
  .COL_X16_W(COL_X16_W), .AP_BIT(AP_BIT), .BA_W(BA_W)
) chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .org_x16(org_x16), .cmd(cmd),
  .col_addr(col_addr), .bank_open(bank_open), .pwr_mode(pwr_mode), .illegal(illegal)
);

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int BURST = 3;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, org_x16 = 1'b0;
  logic [RW-1:0] addr = '0;
  logic [1:0] ba = '0;
  logic [2:0] cmd;
  logic [9:0] col_addr;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] open_row;
  logic [1:0] pwr_mode;
  logic illegal;

  sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .BURST_CYC(BURST)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .org_x16(org_x16), .cmd(cmd),
    .col_addr(col_addr), .bank_open(bank_open), .open_row(open_row),
    .pwr_mode(pwr_mode), .illegal(illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R10";

  int m_open [NB], m_row [NB], m_cnt [NB];
  int m_mode = 0, m_cmd = 0, m_ill = 0, m_col = 0;

  function automatic int decode(logic [2:0] p);
    case (p)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b000: return 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int c, bad, anyo, b0;
    if (rst) begin
      for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_cnt[b] = 0; end
      m_mode = 0; m_cmd = 0; m_ill = 0; m_col = 0;
    end else begin
      anyo = 0;
      for (int b = 0; b < NB; b++) if (m_open[b] != 0) anyo = 1;
      b0 = int'(ba);
      if (cs_n) c = 0;
      else if (m_mode == 0 && cke) c = decode({ras_n, cas_n, we_n});
      else if (m_mode == 0 && !cke && decode({ras_n, cas_n, we_n}) == 5) c = 7;
      else c = 0;
      bad = 0;
      if ((c == 2 || c == 3) && (m_open[b0] == 0 || m_cnt[b0] > 0)) bad = 1;
      if (c == 1 && m_open[b0] != 0) bad = 1;
      if ((c == 5 || c == 7) && anyo != 0) bad = 1;
      m_col = (c == 2 || c == 3) ? (int'(addr) & (org_x16 ? 'h1FF : 'h3FF)) : 0;
      for (int b = 0; b < NB; b++)
        if (m_cnt[b] > 0) begin
          m_cnt[b]--;
          if (m_cnt[b] == 0) m_open[b] = 0;
        end
      if (bad == 0) begin
        if (c == 1) begin m_open[b0] = 1; m_row[b0] = int'(addr); end
        if (c == 4) begin
          for (int b = 0; b < NB; b++)
            if (addr[10] || b == b0) begin m_open[b] = 0; m_cnt[b] = 0; end
        end
        if ((c == 2 || c == 3) && addr[10]) m_cnt[b0] = BURST;
      end
      if (m_mode == 3) for (int b = 0; b < NB; b++) m_open[b] = 0;
      if (m_mode == 0) begin
        if (!cke) m_mode = (c == 7 && anyo == 0) ? 3 : (anyo != 0 ? 2 : 1);
      end else if (cke) m_mode = 0;
      m_cmd = c; m_ill = bad;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("cmd", int'(cmd), m_cmd);
    chk("illegal", int'(illegal), m_ill);
    chk("col_addr", int'(col_addr), m_col);
    chk("pwr_mode", int'(pwr_mode), m_mode);
    for (int b = 0; b < NB; b++) begin
      chk($sformatf("bank_open[%0d]", b), int'(bank_open[b]), m_open[b]);
      chk($sformatf("open_row[%0d]", b), int'(open_row[b*RW +: RW]), m_open[b] != 0 ? m_row[b] : 0);
    end
  endtask

  task automatic cyc(logic k, logic cs, logic [2:0] p, int a, int bk);
    @(negedge clk);
    compare();
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = p; addr = RW'(a); ba = 2'(bk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 3'b111, 0, 0);
  endtask

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         REF = 3'b001, MRS = 3'b000, NOP = 3'b111;

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10"; chk("reset bank_open", int'(bank_open), 0); chk("reset pwr_mode", int'(pwr_mode), 0);
    chk("reset cmd", int'(cmd), 0);
    rst = 1'b0;
    tag = "R1";
    cyc(1, 1, ACT, 5, 0); cyc(1, 0, MRS, 0, 0); cyc(1, 0, REF, 0, 0); cyc(1, 0, 3'b110, 0, 0);
    cyc(1, 0, NOP, 0, 0); idle(1);
    tag = "R2";
    cyc(1, 0, ACT, 'h0ABC, 0); cyc(1, 0, ACT, 'h1FFF, 2); idle(2);
    tag = "R5";
    org_x16 = 1'b0; cyc(1, 0, RD, 'h3FF, 0); idle(1);
    org_x16 = 1'b1; cyc(1, 0, WR, 'h3FF, 2); idle(1); org_x16 = 1'b0;
    tag = "R6";
    cyc(1, 0, ACT, 'h0123, 0); cyc(1, 0, RD, 5, 1); cyc(1, 0, REF, 0, 0); idle(2);
    tag = "R3";
    cyc(1, 0, PRE, 0, 0); idle(1); cyc(1, 0, ACT, 'h0055, 3); cyc(1, 0, PRE, 'h400, 1); idle(2);
    tag = "R4";
    cyc(1, 0, ACT, 'h0777, 1); cyc(1, 0, WR, 'h404, 1); cyc(1, 0, RD, 'h004, 1);
    cyc(1, 0, ACT, 'h0111, 1); idle(4); cyc(1, 0, ACT, 'h0222, 1);
    cyc(1, 0, RD, 'h408, 1); cyc(1, 0, PRE, 0, 1); idle(3);
    tag = "R7";
    cyc(0, 1, NOP, 0, 0); cyc(0, 0, ACT, 3, 0); cyc(0, 1, NOP, 0, 0); cyc(1, 0, ACT, 9, 2); idle(2);
    cyc(1, 0, ACT, 'h0333, 3); cyc(0, 1, NOP, 0, 0); cyc(0, 1, NOP, 0, 0); cyc(1, 1, NOP, 0, 0); idle(1);
    cyc(1, 0, RD, 'h400, 3); cyc(0, 1, NOP, 0, 0); idle(5);
    tag = "R8";
    cyc(1, 0, PRE, 'h400, 0); cyc(0, 0, REF, 0, 0); cyc(0, 0, ACT, 4, 0); cyc(0, 1, NOP, 0, 0);
    cyc(1, 1, NOP, 0, 0); idle(2);
    cyc(1, 0, ACT, 'h0444, 0); cyc(0, 0, REF, 0, 0); cyc(0, 1, NOP, 0, 0); cyc(1, 0, PRE, 'h400, 0); idle(2);
    tag = "R9";
    cyc(0, 0, REF, 0, 0); cyc(0, 0, RD, 0, 0); cyc(1, 0, ACT, 7, 1); idle(2);
    tag = "R10";
    cyc(1, 0, ACT, 'h0099, 2); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      logic [2:0] p;
      p = 3'($urandom_range(0, 7));
      org_x16 = 1'($urandom_range(0, 1));
      cyc(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 3) == 0), p,
          int'($urandom_range(0, 'h1FFF)), int'($urandom_range(0, 3)));
    end
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule